// File: doc/BRIEF.md
# Bundle Predication and Issue-Group Marker

This block sits behind the field extractor of a long-instruction front end. For one bundle per strobe it takes the control bits of each slot and works out two things for every operation the bundle carries. The first is whether the operation is allowed to execute, given its predicate bit, a shared sense bit and one selected bit of the flag register. The second is whether the operation opens a new parallel-issue group or may issue together with the operation before it.

Each slot holds either one 32-bit operation or a pair of short operations, so every slot maps to two operation positions. The second position is used only when the slot holds a pair.

There are two modes. In single-slot mode only slot 0 is decoded, and it uses its own sense bit and flag selector. In quad mode four slots are decoded, each with its own predicate bit, and all of them share one sense bit and one flag selector. The results are registered and appear one cycle after the input strobe.

Top module: `bundle_issue_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with no strobe, `out_valid`, `op_valid`, `op_exec` and `op_group_start` are all zero.
- R2: An operation in a slot whose predicate bit is 0 has `op_exec` set, whatever the flag register and sense bit hold.
- R3: An operation in a predicated slot has `op_exec` set exactly when the selected flag is 1 with `sense`=0, or when the selected flag is 0 with `sense`=1.
- R4: The selected flag is `flags[flag_sel]`, where `flag_sel` is an unsigned index from 0 to 15 and bit n of `flags` is flag n.
- R5: When `quad_mode`=1, slots 0 to 3 are all decoded. They share `sense` and `flag_sel`, and each slot uses its own bit of `slot_pred`. When `quad_mode`=0, only slot 0 is decoded, and operation positions 2 to 7 have valid, exec and group-start all 0.
- R6: The first operation of a valid slot s (position 2s) has `op_group_start` equal to `slot_brk[s]`, where 1 means it starts a new issue group.
- R7: `pair_kind[2s+1:2s]` encodes the pair type: 00 is int/int, 01 is fp/fp, 10 is int/fp, 11 is fp/int. For a same-type pair (00 or 01), the second operation (position 2s+1) has `op_group_start` equal to `pair_brk[s]`.
- R8: For a mixed pair (`pair_kind` bit 1 set), the second operation has `op_group_start` equal to 0, whatever `pair_brk[s]` holds.
- R9: Both operations of a pair slot receive the same `op_exec` value, which is the slot's predicate result.
- R10: For a valid slot with `slot_is_pair[s]`=0, position 2s+1 has valid, exec and group-start all 0.
- R11: All outputs are registered. The results for a bundle strobed with `in_valid` in cycle n appear in cycle n+1. A cycle without `in_valid` gives `out_valid`=0 and all operation vectors 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle control bits are present this cycle |
| quad_mode | input | 1 | 1: four slots share sense and flag selector; 0: slot 0 only |
| slot_pred | input | NUM_SLOTS | Per-slot predicate enable |
| slot_brk | input | NUM_SLOTS | Per-slot break bit (1 = new group) |
| sense | input | 1 | Predicate sense (0: run on flag set, 1: run on flag clear) |
| flag_sel | input | 4 | Index of the controlling flag |
| flags | input | FLAG_COUNT | Flag register |
| slot_is_pair | input | NUM_SLOTS | Slot holds a short pair |
| pair_kind | input | 2*NUM_SLOTS | Pair type per slot, 2 bits each |
| pair_brk | input | NUM_SLOTS | Break bit inside a same-type pair |
| out_valid | output | 1 | Registered results are valid |
| op_valid | output | 2*NUM_SLOTS | Operation position holds an operation |
| op_exec | output | 2*NUM_SLOTS | Operation may execute |
| op_group_start | output | 2*NUM_SLOTS | Operation starts a new issue group |

## Verification
The bench builds the block with its defaults: four slots and a 16-bit flag register. This brings every slot position, both modes and every flag index within reach of a single build. A behavioural reference model recomputes all three operation vectors from the driven fields, and the bench compares them every cycle. Directed bundles cover the sense inversion, a shared selector against mixed per-slot predicate bits, and mixed pairs that carry a set break bit. Several thousand random bundles follow, drawing all four pair types and both modes.

// File: rtl/bundle_issue_pkg.sv
package bundle_issue_pkg;

   // Short-pair type code carried per slot.
   typedef enum logic [1:0] {
      PAIR_INT_INT = 2'b00,
      PAIR_FP_FP   = 2'b01,
      PAIR_INT_FP  = 2'b10,
      PAIR_FP_INT  = 2'b11
   } pair_kind_e;

   // Mixed pairs use separate units and register banks.
   function automatic logic pair_is_mixed(input logic [1:0] kind);
      return kind[1];
   endfunction

endpackage

// File: rtl/bundle_pred_eval.sv
module bundle_pred_eval #(
   parameter int NUM_SLOTS  = 4,
   parameter int FLAG_COUNT = 16,
   localparam int SEL_W     = $clog2(FLAG_COUNT)
) (
   input  logic [FLAG_COUNT-1:0] flags,
   input  logic [SEL_W-1:0]      flag_sel,
   input  logic                  sense,
   input  logic [NUM_SLOTS-1:0]  slot_pred,
   output logic [NUM_SLOTS-1:0]  slot_run
);
   logic sel_bit;
   logic cond_met;

   always_comb begin
      sel_bit  = flags[flag_sel];
      cond_met = sel_bit ^ sense;
   end

   // One shared condition, gated per slot by its own predicate bit.
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_run
      assign slot_run[s] = ~slot_pred[s] | cond_met;
   end
endmodule

// File: rtl/bundle_slot_map.sv
module bundle_slot_map
   import bundle_issue_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   localparam int NUM_OPS  = 2 * NUM_SLOTS
) (
   input  logic                   in_valid,
   input  logic                   quad_mode,
   input  logic [NUM_SLOTS-1:0]   slot_run,
   input  logic [NUM_SLOTS-1:0]   slot_brk,
   input  logic [NUM_SLOTS-1:0]   slot_is_pair,
   input  logic [2*NUM_SLOTS-1:0] pair_kind,
   input  logic [NUM_SLOTS-1:0]   pair_brk,
   output logic [NUM_OPS-1:0]     nxt_valid,
   output logic [NUM_OPS-1:0]     nxt_exec,
   output logic [NUM_OPS-1:0]     nxt_grp
);
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic live;
      logic second_live;
      logic same_type;

      // Slot 0 is decoded in both modes; the others only in quad mode.
      if (s == 0) begin : g_lead
         assign live = in_valid;
      end else begin : g_tail
         assign live = in_valid & quad_mode;
      end

      assign second_live = live & slot_is_pair[s];
      assign same_type   = ~pair_is_mixed(pair_kind[2*s +: 2]);

      assign nxt_valid[2*s]   = live;
      assign nxt_exec[2*s]    = live & slot_run[s];
      assign nxt_grp[2*s]     = live & slot_brk[s];

      assign nxt_valid[2*s+1] = second_live;
      assign nxt_exec[2*s+1]  = second_live & slot_run[s];
      assign nxt_grp[2*s+1]   = second_live & same_type & pair_brk[s];
   end
endmodule

// File: rtl/bundle_issue_gate.sv
module bundle_issue_gate #(
   parameter int NUM_SLOTS  = 4,
   parameter int FLAG_COUNT = 16,
   localparam int SEL_W     = $clog2(FLAG_COUNT),
   localparam int NUM_OPS   = 2 * NUM_SLOTS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   quad_mode,
   input  logic [NUM_SLOTS-1:0]   slot_pred,
   input  logic [NUM_SLOTS-1:0]   slot_brk,
   input  logic                   sense,
   input  logic [SEL_W-1:0]       flag_sel,
   input  logic [FLAG_COUNT-1:0]  flags,
   input  logic [NUM_SLOTS-1:0]   slot_is_pair,
   input  logic [2*NUM_SLOTS-1:0] pair_kind,
   input  logic [NUM_SLOTS-1:0]   pair_brk,
   output logic                   out_valid,
   output logic [NUM_OPS-1:0]     op_valid,
   output logic [NUM_OPS-1:0]     op_exec,
   output logic [NUM_OPS-1:0]     op_group_start
);
   // Elaboration-time parameter checks.
   if (NUM_SLOTS < 1 || NUM_SLOTS > 4) begin : g_bad_slots
      $error("bundle_issue_gate: NUM_SLOTS must be 1..4");
   end
   if (FLAG_COUNT < 2 || (FLAG_COUNT & (FLAG_COUNT - 1)) != 0) begin : g_bad_flags
      $error("bundle_issue_gate: FLAG_COUNT must be a power of two >= 2");
   end

   logic [NUM_SLOTS-1:0] slot_run;
   logic [NUM_OPS-1:0]   nxt_valid;
   logic [NUM_OPS-1:0]   nxt_exec;
   logic [NUM_OPS-1:0]   nxt_grp;

   bundle_pred_eval #(
      .NUM_SLOTS  (NUM_SLOTS),
      .FLAG_COUNT (FLAG_COUNT)
   ) u_pred (
      .flags     (flags),
      .flag_sel  (flag_sel),
      .sense     (sense),
      .slot_pred (slot_pred),
      .slot_run  (slot_run)
   );

   bundle_slot_map #(
      .NUM_SLOTS (NUM_SLOTS)
   ) u_map (
      .in_valid     (in_valid),
      .quad_mode    (quad_mode),
      .slot_run     (slot_run),
      .slot_brk     (slot_brk),
      .slot_is_pair (slot_is_pair),
      .pair_kind    (pair_kind),
      .pair_brk     (pair_brk),
      .nxt_valid    (nxt_valid),
      .nxt_exec     (nxt_exec),
      .nxt_grp      (nxt_grp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid      <= 1'b0;
         op_valid       <= '0;
         op_exec        <= '0;
         op_group_start <= '0;
      end else begin
         out_valid      <= in_valid;
         op_valid       <= nxt_valid;
         op_exec        <= nxt_exec;
         op_group_start <= nxt_grp;
      end
   end
endmodule

// File: rtl/bundle_issue_gate_chk.sv
module bundle_issue_gate_chk #(
   parameter int NUM_SLOTS  = 4,
   parameter int FLAG_COUNT = 16,
   localparam int SEL_W     = $clog2(FLAG_COUNT),
   localparam int NUM_OPS   = 2 * NUM_SLOTS
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   quad_mode,
   input logic [NUM_SLOTS-1:0]   slot_pred,
   input logic [NUM_SLOTS-1:0]   slot_brk,
   input logic                   sense,
   input logic [SEL_W-1:0]       flag_sel,
   input logic [FLAG_COUNT-1:0]  flags,
   input logic [NUM_SLOTS-1:0]   slot_is_pair,
   input logic [2*NUM_SLOTS-1:0] pair_kind,
   input logic [NUM_SLOTS-1:0]   pair_brk,
   input logic                   out_valid,
   input logic [NUM_OPS-1:0]     op_valid,
   input logic [NUM_OPS-1:0]     op_exec,
   input logic [NUM_OPS-1:0]     op_group_start
);
   // R2: an unpredicated slot 0 always executes.
   a_r2_unpred_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !slot_pred[0]) |=> op_exec[0]);

   // R3: predicated with a failing condition is suppressed.
   a_r3_pred_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && slot_pred[0] && (flags[flag_sel] == sense)) |=> !op_exec[0]);

   // R6: the first operation carries the slot break bit.
   a_r6_slot_break: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (op_group_start[0] == $past(slot_brk[0])));

   // R8: a mixed pair never breaks internally.
   a_r8_mixed_parallel: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && slot_is_pair[0] && pair_kind[1]) |=> (op_valid[1] && !op_group_start[1]));

   // R9: both halves of a pair share the predicate result.
   a_r9_pair_same_exec: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && slot_is_pair[0]) |=> (op_exec[1] == op_exec[0]));

   // R5: single-slot mode leaves the upper positions empty.
   a_r5_single_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !quad_mode) |=> (op_valid[NUM_OPS-1:2] == '0));

   // R10: an invalid position never executes nor starts a group.
   a_r10_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_exec & ~op_valid) == '0) && ((op_group_start & ~op_valid) == '0));

   // R11: an idle cycle yields an empty result next cycle.
   a_r11_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && op_valid == '0));
endmodule

bind bundle_issue_gate bundle_issue_gate_chk #(
   .NUM_SLOTS  (NUM_SLOTS),
   .FLAG_COUNT (FLAG_COUNT)
) u_chk (.*);

// File: tb/bundle_issue_gate_bench.sv
module bundle_issue_gate_bench;
   localparam int NS = 4;
   localparam int NF = 16;
   localparam int NO = 2 * NS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic quad_mode = 1'b0;
   logic [NS-1:0] slot_pred = '0;
   logic [NS-1:0] slot_brk = '0;
   logic sense = 1'b0;
   logic [3:0] flag_sel = '0;
   logic [NF-1:0] flags = '0;
   logic [NS-1:0] slot_is_pair = '0;
   logic [2*NS-1:0] pair_kind = '0;
   logic [NS-1:0] pair_brk = '0;
   logic out_valid;
   logic [NO-1:0] op_valid, op_exec, op_group_start;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic exp_ov;
   logic [NO-1:0] exp_v, exp_e, exp_g;

   always #5 clk = ~clk;

   bundle_issue_gate #(.NUM_SLOTS(NS), .FLAG_COUNT(NF)) u_bundle_issue_gate (.*);

   // Behavioural reference: derives expectations directly from the rules.
   task automatic model();
      exp_ov = in_valid;
      for (int i = 0; i < NO; i++) begin
         int s = i / 2;
         bit second = (i % 2) == 1;
         bit active = in_valid && (s == 0 || quad_mode);
         bit present = active && (!second || slot_is_pair[s]);
         bit cond = (flags[flag_sel] != sense);
         bit run = !slot_pred[s] || cond;
         bit mixed = pair_kind[2*s+1];
         exp_v[i] = present;
         exp_e[i] = present && run;
         if (second) exp_g[i] = present && !mixed && pair_brk[s];
         else        exp_g[i] = present && slot_brk[s];
      end
   endtask

   task automatic cmp(string tag, string what, logic [NO-1:0] act, logic [NO-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   // Drive at a falling edge, check at the next falling edge.
   task automatic apply(string tag);
      model();
      @(negedge clk);
      cmp(tag, "out_valid", {{(NO-1){1'b0}}, out_valid}, {{(NO-1){1'b0}}, exp_ov});
      cmp(tag, "op_valid", op_valid, exp_v);
      cmp(tag, "op_exec", op_exec, exp_e);
      cmp(tag, "op_group_start", op_group_start, exp_g);
   endtask

   task automatic clear_fields();
      in_valid = 1; quad_mode = 0; slot_pred = '0; slot_brk = '0; sense = 0;
      flag_sel = '0; flags = '0; slot_is_pair = '0; pair_kind = '0; pair_brk = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs cleared under reset
      in_valid = 0;
      model();
      cmp("R1", "op_valid", op_valid, '0);
      cmp("R1", "op_exec", op_exec, '0);
      rst_n = 1;
      @(negedge clk);
      cmp("R1", "op_group_start", op_group_start, '0);
      cmp("R1", "out_valid", {{(NO-1){1'b0}}, out_valid}, '0);

      // R2: unpredicated runs regardless of flag
      clear_fields(); flags = '0; sense = 0; apply("R2");
      clear_fields(); flags = '1; sense = 1; apply("R2");
      // R3: sense selects polarity
      clear_fields(); slot_pred = 4'b0001; flags = 16'h0001; sense = 0; apply("R3");
      clear_fields(); slot_pred = 4'b0001; flags = 16'h0001; sense = 1; apply("R3");
      clear_fields(); slot_pred = 4'b0001; flags = 16'h0000; sense = 1; apply("R3");
      // R4: flag index chooses the bit
      clear_fields(); slot_pred = 4'b0001; flags = 16'h0100; flag_sel = 4'd8; apply("R4");
      clear_fields(); slot_pred = 4'b0001; flags = 16'h0100; flag_sel = 4'd7; apply("R4");
      clear_fields(); slot_pred = 4'b0001; flags = 16'h8000; flag_sel = 4'd15; apply("R4");
      // R5: quad mode with shared selector, then single mode hiding slots 1..3
      clear_fields(); quad_mode = 1; slot_pred = 4'b1010; flags = 16'h0000; apply("R5");
      clear_fields(); quad_mode = 1; slot_pred = 4'b1010; flags = 16'h0000; sense = 1; apply("R5");
      clear_fields(); quad_mode = 0; slot_is_pair = '1; slot_brk = '1; apply("R5");
      // R6: per-slot break bits
      clear_fields(); quad_mode = 1; slot_brk = 4'b0101; apply("R6");
      // R7: same-type pairs follow the inner break
      clear_fields(); quad_mode = 1; slot_is_pair = '1; pair_kind = 8'b01_00_01_00; pair_brk = 4'b0110; apply("R7");
      // R8: mixed pairs ignore the inner break
      clear_fields(); quad_mode = 1; slot_is_pair = '1; pair_kind = 8'b11_10_11_10; pair_brk = 4'b1111; apply("R8");
      // R9: pair halves share the predicate result
      clear_fields(); quad_mode = 1; slot_is_pair = '1; slot_pred = 4'b0011; flags = '0; apply("R9");
      // R10: non-pair second position empty
      clear_fields(); quad_mode = 1; slot_is_pair = 4'b0000; pair_brk = '1; slot_brk = '1; apply("R10");
      // R11: idle cycle clears output
      clear_fields(); in_valid = 0; slot_brk = '1; apply("R11");

      // Random bundles, checked every cycle (R11 timing for all fields)
      for (int n = 0; n < 3000; n++) begin
         in_valid = ($urandom_range(0, 7) != 0);
         quad_mode = $urandom_range(0, 1);
         slot_pred = NS'($urandom);
         slot_brk = NS'($urandom);
         sense = $urandom_range(0, 1);
         flag_sel = 4'($urandom);
         flags = NF'($urandom);
         slot_is_pair = NS'($urandom);
         pair_kind = (2*NS)'($urandom);
         pair_brk = NS'($urandom);
         apply("R11");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule